// File: doc/BRIEF.md
# Cyclic Sample Descriptor Ring Writer

This block takes a stream of complex baseband samples from a converter and packs them into fixed 128-byte descriptors. Each descriptor holds a 16-byte header and 28 sample words, and the descriptors sit in a ring of equal slots in memory. The ring has a parameter number of slots and starts at a parameter base address. A consumer polls the published write index. It reads every descriptor between its own read index and that write index, and it hands a slot back by pulsing an advance input.

The memory side is a single registered word-write port with a byte address, 32-bit data and a write strobe. Sample words are written as they arrive. The header is written in cycles that carry no sample. The header word that holds the valid bit goes out last, so a slot appears complete only when its header is valid. When every slot is still held by the consumer, new samples are dropped at a descriptor boundary and a flag is raised. Slots the consumer owns are never overwritten.

Top module: `sample_ring_writer`

## Requirements
- R1: Sample k of a descriptor (k = 0..27, in order of arrival) is written as one word at slot base + 16 + 4*k. The data is Q in bits 31:16 and I in bits 15:0.
- R2: Slot s has base address BASE_ADDR + 128*s. After slot SLOTS-1, filling wraps back to slot 0, and the published write index wraps the same way.
- R3: Header word 0, at slot base + 0, holds valid = 1 in bit 0, the frame bit in bit 1, the sequence number in bits 31:16, and zero in every other bit. Header words 1, 2 and 3, at slot base + 4, 8 and 12, are written as zero.
- R4: All 28 sample words of a slot are written before its header. The header words go out in the order 1, 2, 3, 0. The write index advances by one in the cycle after the write of header word 0 appears on the port.
- R5: A sample that would open a new descriptor while all SLOTS slots are published, awaiting publication or unreleased is dropped, and nothing is written for it. The overflow output is high from the cycle after a dropped sample and returns low in the cycle after a sample is accepted.
- R6: The sequence number starts at 0 after reset and goes up by one for each completed descriptor. It wraps modulo 2^16.
- R7: A pulse on rd_advance moves rd_index one slot forward, with wraparound, when at least one published descriptor is unreleased. When none is, the pulse is ignored and rd_index keeps its value.
- R8: The frame bit of a header is 1 exactly when frame_mark was high together with at least one accepted sample of that descriptor.
- R9: In reset, the write strobe, the write index, the read index and the overflow flag are all low.
- R10: A sample accepted at a clock edge appears as a write on the memory port in the cycle that follows. Header words use only cycles in which no sample is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_i | input | 16 | In-phase component |
| smp_q | input | 16 | Quadrature component |
| frame_mark | input | 1 | Frame indicator, sampled with each sample |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the word being written |
| mem_wdata | output | 32 | Data word being written |
| wr_index | output | clog2(SLOTS) | Next slot to be published |
| rd_advance | input | 1 | Consumer releases the slot at rd_index |
| rd_index | output | clog2(SLOTS) | Oldest slot the consumer still holds |
| overflow | output | 1 | Samples are being dropped for lack of a free slot |

## Verification
A sample write is due on the port one cycle after its acceptance edge. The overflow flag and rd_index settle one cycle after the edge that drops a sample or takes an advance pulse. The write index moves one cycle after the port shows header word 0. The driver pushes every expected word into a sample queue or a header queue in the order the requirements fix. A monitor on the falling edge pops those queues whenever the strobe is high and checks the write index at the falling edge after each header word 0. Direct probes of overflow, rd_index and the first write of a descriptor are taken at the falling edge that follows the causing rising edge. That way every sample lands half a period after the registers have settled.

// File: rtl/srw_pkg.sv
// Package: descriptor layout constants and the header word type for the ring writer.
// Assumes the layout is fixed (128-byte slots, 16-byte header, 28 samples).
package srw_pkg;
    localparam int DESC_SHIFT   = 7;
    localparam int DESC_BYTES   = 1 << DESC_SHIFT;
    localparam int HDR_BYTES    = 16;
    localparam int SMP_PER_DESC = (DESC_BYTES - HDR_BYTES) / 4;
    localparam int SMP_IDX_W    = $clog2(SMP_PER_DESC);
    localparam int HW_IDX_W     = 2;
    localparam int SEQ_W        = 16;

    typedef struct packed {
        logic [SEQ_W-1:0] seq;
        logic [13:0]      rsvd;
        logic             frame;
        logic             valid;
    } hdr_word0_t;
endpackage

// File: rtl/ring_slot_tracker.sv
// Module: tracks the published write index, the consumer read index and the
// count of published-but-unreleased slots.
// Assumes publish pulses arrive in slot order and at most one per cycle.
module ring_slot_tracker #(
    parameter int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             publish,
    input  logic             rd_advance,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] avail
);
    logic take;

    // Purpose: a release counts only while something is published.
    assign take = rd_advance && (avail != '0);

    // Purpose: advance both indices with wraparound and keep the count in step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_idx <= '0;
            rd_idx <= '0;
            avail  <= '0;
        end else begin
            if (publish)
                wr_idx <= (wr_idx == IDX_W'(SLOTS - 1)) ? '0 : wr_idx + 1'b1;
            if (take)
                rd_idx <= (rd_idx == IDX_W'(SLOTS - 1)) ? '0 : rd_idx + 1'b1;
            avail <= avail + CNT_W'(publish) - CNT_W'(take);
        end
    end

    p_avail_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= CNT_W'(SLOTS));

    p_rd_hold_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_advance && avail == '0) |=> $stable(rd_idx));
endmodule

// File: rtl/desc_fill_ctrl.sv
// Module: counts samples into the current descriptor, decides between accepting
// and dropping, and sequences the header words once a descriptor is full.
// Assumes the producer leaves at least four idle cycles within the 28 samples
// that follow a full descriptor, so one header is pending at most.
module desc_fill_ctrl
    import srw_pkg::*;
#(
    parameter int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic                 frame_mark,
    input  logic                 slot_free,
    output logic                 accept,
    output logic [SMP_IDX_W-1:0] smp_idx,
    output logic [IDX_W-1:0]     fill_idx,
    output logic                 hdr_pending,
    output logic                 hdr_issue,
    output logic [HW_IDX_W-1:0]  hdr_word,
    output logic [SEQ_W-1:0]     hdr_seq,
    output logic                 hdr_frame,
    output logic                 overflow
);
    logic             frame_acc;
    logic [SEQ_W-1:0] seq;
    logic             last_smp;

    // Purpose: opening a descriptor needs a free slot; continuing one never does.
    assign accept    = smp_valid && ((smp_idx != '0) || slot_free);
    assign hdr_issue = hdr_pending && !accept;
    assign last_smp  = (smp_idx == SMP_IDX_W'(SMP_PER_DESC - 1));

    // Purpose: sample counting, descriptor close, header word stepping, drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_idx     <= '0;
            fill_idx    <= '0;
            frame_acc   <= 1'b0;
            seq         <= '0;
            hdr_pending <= 1'b0;
            hdr_word    <= '0;
            hdr_seq     <= '0;
            hdr_frame   <= 1'b0;
            overflow    <= 1'b0;
        end else begin
            if (smp_valid)
                overflow <= !accept;
            if (accept) begin
                if (last_smp) begin
                    smp_idx     <= '0;
                    fill_idx    <= (fill_idx == IDX_W'(SLOTS - 1)) ? '0 : fill_idx + 1'b1;
                    hdr_pending <= 1'b1;
                    hdr_word    <= HW_IDX_W'(1);
                    hdr_seq     <= seq;
                    hdr_frame   <= frame_acc | frame_mark;
                    seq         <= seq + 1'b1;
                    frame_acc   <= 1'b0;
                end else begin
                    smp_idx   <= smp_idx + 1'b1;
                    frame_acc <= frame_acc | frame_mark;
                end
            end else if (hdr_issue) begin
                hdr_word <= hdr_word + 1'b1;
                if (hdr_word == '0)
                    hdr_pending <= 1'b0;
            end
        end
    end

    p_drop_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !accept) |=> overflow);

    p_one_header_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && last_smp && hdr_pending));
endmodule

// File: rtl/ring_write_port.sv
// Module: forms byte addresses and data words for the memory port and registers them.
// Assumes the caller never asserts accept and hdr_issue together.
module ring_write_port
    import srw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [SMP_IDX_W-1:0] smp_idx,
    input  logic [15:0]          smp_i,
    input  logic [15:0]          smp_q,
    input  logic                 hdr_issue,
    input  logic [HW_IDX_W-1:0]  hdr_word,
    input  logic [IDX_W-1:0]     hdr_idx,
    input  logic [SEQ_W-1:0]     hdr_seq,
    input  logic                 hdr_frame,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [31:0]          mem_wdata
);
    logic [ADDR_W-1:0] smp_base, hdr_base;
    hdr_word0_t        w0;

    // Purpose: slot base addresses and the header word 0 layout.
    always_comb begin
        smp_base  = BASE_ADDR + (ADDR_W'(fill_idx) << DESC_SHIFT);
        hdr_base  = BASE_ADDR + (ADDR_W'(hdr_idx) << DESC_SHIFT);
        w0.seq    = hdr_seq;
        w0.rsvd   = '0;
        w0.frame  = hdr_frame;
        w0.valid  = 1'b1;
    end

    // Purpose: one registered write per cycle, a sample taking precedence over a header word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= accept || hdr_issue;
            if (accept) begin
                mem_addr  <= smp_base + ADDR_W'(HDR_BYTES) + (ADDR_W'(smp_idx) << 2);
                mem_wdata <= {smp_q, smp_i};
            end else if (hdr_issue) begin
                mem_addr  <= hdr_base + (ADDR_W'(hdr_word) << 2);
                mem_wdata <= (hdr_word == '0) ? w0 : 32'h0;
            end
        end
    end
endmodule

// File: rtl/sample_ring_writer.sv
// Module: top of the ring writer. Packs I/Q samples into 128-byte descriptors in
// a ring of SLOTS slots and publishes each slot once its header is valid.
// Assumes BASE_ADDR is aligned to 128 bytes and the memory accepts one write per cycle.
module sample_ring_writer
    import srw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter int SLOTS = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [15:0]       smp_i,
    input  logic [15:0]       smp_q,
    input  logic              frame_mark,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [IDX_W-1:0]  wr_index,
    input  logic              rd_advance,
    output logic [IDX_W-1:0]  rd_index,
    output logic              overflow
);
    logic                 accept, hdr_pending, hdr_issue, hdr_frame, publish_q, slot_free;
    logic [SMP_IDX_W-1:0] smp_idx;
    logic [IDX_W-1:0]     fill_idx;
    logic [HW_IDX_W-1:0]  hdr_word;
    logic [SEQ_W-1:0]     hdr_seq;
    logic [CNT_W-1:0]     avail;
    logic [CNT_W:0]       occupied;

    // Purpose: a slot is taken once it is full, until the consumer releases it.
    assign occupied  = {1'b0, avail} + (CNT_W+1)'(hdr_pending) + (CNT_W+1)'(publish_q);
    assign slot_free = occupied < (CNT_W+1)'(SLOTS);

    // Purpose: publish one cycle after header word 0 is on the port, once memory holds it.
    always_ff @(posedge clk) begin
        if (!rst_n) publish_q <= 1'b0;
        else        publish_q <= hdr_issue && (hdr_word == '0);
    end

    desc_fill_ctrl #(.SLOTS(SLOTS)) fill_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .frame_mark(frame_mark),
        .slot_free(slot_free), .accept(accept), .smp_idx(smp_idx), .fill_idx(fill_idx),
        .hdr_pending(hdr_pending), .hdr_issue(hdr_issue), .hdr_word(hdr_word),
        .hdr_seq(hdr_seq), .hdr_frame(hdr_frame), .overflow(overflow)
    );

    ring_slot_tracker #(.SLOTS(SLOTS)) track_i (
        .clk(clk), .rst_n(rst_n), .publish(publish_q), .rd_advance(rd_advance),
        .wr_idx(wr_index), .rd_idx(rd_index), .avail(avail)
    );

    ring_write_port #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IDX_W(IDX_W)) port_i (
        .clk(clk), .rst_n(rst_n), .accept(accept), .fill_idx(fill_idx), .smp_idx(smp_idx),
        .smp_i(smp_i), .smp_q(smp_q), .hdr_issue(hdr_issue), .hdr_word(hdr_word),
        .hdr_idx(wr_index), .hdr_seq(hdr_seq), .hdr_frame(hdr_frame),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    p_word_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[1:0] == 2'b00));

    p_publish_after_hdr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_index != $past(wr_index)) |->
            ($past(mem_we) && ($past(mem_addr[DESC_SHIFT-1:0]) == '0)));
endmodule

// File: tb/sample_ring_writer_tb.sv
// Bench: a scoreboard with a driver that queues the expected memory writes and
// a falling-edge monitor that pops and compares them as the port shows them.
module sample_ring_writer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SLOTS      = 4;
    localparam int ADDR_W     = 32;
    localparam logic [31:0] BASE = 32'h0000_4000;

    logic        clk, rst_n, smp_valid, frame_mark, rd_advance;
    logic [15:0] smp_i, smp_q;
    logic        mem_we, overflow;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0]  wr_index, rd_index;

    sample_ring_writer #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .SLOTS(SLOTS)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_i(smp_i), .smp_q(smp_q),
        .frame_mark(frame_mark), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_index(wr_index), .rd_advance(rd_advance), .rd_index(rd_index), .overflow(overflow)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    logic [63:0] q_smp[$], q_hdr[$];
    int b_cnt = 0, b_occ = 0, b_fill = 0, b_seq = 0, pat = 0;
    bit b_frame = 0;
    int exp_wr = 0, obs_cnt[SLOTS];
    bit pub_chk = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            smp_valid = 1'b0; frame_mark = 1'b0;
        end
    endtask

    // Driver: predicts acceptance, queues the expected writes, then presents the sample.
    task automatic send(input logic [15:0] i, input logic [15:0] q, input bit fm, output bit acc);
        logic [31:0] a;
        acc = (b_cnt != 0) || (b_occ < SLOTS);
        @(negedge clk);
        smp_valid = 1'b1; smp_i = i; smp_q = q; frame_mark = fm;
        if (acc) begin
            a = BASE + 32'(b_fill * 128 + 16 + 4 * b_cnt);
            q_smp.push_back({a, q, i});
            b_frame |= fm;
            if (b_cnt == 27) begin
                a = BASE + 32'(b_fill * 128);
                q_hdr.push_back({a + 32'd4, 32'h0});
                q_hdr.push_back({a + 32'd8, 32'h0});
                q_hdr.push_back({a + 32'd12, 32'h0});
                q_hdr.push_back({a, 16'(b_seq), 14'h0, b_frame, 1'b1});
                b_seq++; b_frame = 0; b_cnt = 0; b_fill = (b_fill + 1) % SLOTS; b_occ++;
            end else begin
                b_cnt++;
            end
        end
        @(posedge clk);
    endtask

    // One descriptor; gap inserts an idle cycle after each sample, fm_pos marks a frame.
    task automatic send_desc(input bit gap, input int fm_pos, input bit probe);
        bit acc;
        logic [31:0] a;
        for (int k = 0; k < 28; k++) begin
            a = BASE + 32'(b_fill * 128 + 16 + 4 * b_cnt);
            send(16'(pat), 16'(pat * 7 + 16'h5000), k == fm_pos, acc);
            pat++;
            if (probe && k == 0) begin
                @(negedge clk);
                smp_valid = 1'b0; frame_mark = 1'b0;
                check(mem_we === 1'b1 && mem_addr === a, "R10", "write due one cycle after accept",
                      {31'h0, mem_we, mem_addr}, {32'h1, a});
            end else if (gap) begin
                idle(1);
            end
        end
        idle(6);
    endtask

    task automatic consume;
        @(negedge clk);
        rd_advance = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_advance = 1'b0;
        if (b_occ > 0) b_occ--;
    endtask

    // Monitor: classify each write as header or sample word and compare against the queues.
    always @(negedge clk) begin
        logic [63:0] e;
        int slot;
        if (pub_chk) begin
            check(wr_index === 2'(exp_wr), "R4", "write index one cycle after header word 0",
                  64'(wr_index), 64'(exp_wr));
            pub_chk = 0;
        end
        if (rst_n && mem_we) begin
            slot = int'((mem_addr - BASE) >> 7) % SLOTS;
            if (mem_addr[6:0] < 7'd16) begin
                if (q_hdr.size() == 0) begin
                    check(0, "R3", "unexpected header write", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    e = q_hdr.pop_front();
                    check({mem_addr, mem_wdata} === e, "R3", "header word / order",
                          {mem_addr, mem_wdata}, e);
                    if (mem_addr[6:0] == 7'd0) begin
                        check(obs_cnt[slot] == 28, "R4", "samples written before header",
                              64'(obs_cnt[slot]), 64'd28);
                        obs_cnt[slot] = 0;
                        exp_wr = (exp_wr + 1) % SLOTS;
                        pub_chk = 1;
                    end
                end
            end else begin
                if (q_smp.size() == 0) begin
                    check(0, "R5", "write for a sample that should drop", {mem_addr, mem_wdata}, 64'h0);
                end else begin
                    e = q_smp.pop_front();
                    check({mem_addr, mem_wdata} === e, "R1", "sample word placement",
                          {mem_addr, mem_wdata}, e);
                    obs_cnt[slot]++;
                end
            end
        end
    end

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit acc;
        for (int s = 0; s < SLOTS; s++) obs_cnt[s] = 0;
        rst_n = 1'b0; smp_valid = 1'b0; frame_mark = 1'b0; rd_advance = 1'b0;
        smp_i = '0; smp_q = '0;
        repeat (3) @(negedge clk);
        check(mem_we === 1'b0, "R9", "strobe in reset", 64'(mem_we), 64'd0);
        check(wr_index === 2'd0 && rd_index === 2'd0, "R9", "indices in reset",
              {wr_index, rd_index}, 64'd0);
        check(overflow === 1'b0, "R9", "overflow in reset", 64'(overflow), 64'd0);
        rst_n = 1'b1;
        idle(2);

        consume();
        check(rd_index === 2'd0, "R7", "advance with nothing published", 64'(rd_index), 64'd0);

        // Four back-to-back descriptors fill the ring; frames and seq checked in headers (R6, R8).
        send_desc(1'b0, -1, 1'b1);
        check(wr_index === 2'd1, "R2", "first slot published", 64'(wr_index), 64'd1);
        send_desc(1'b0, 13, 1'b0);
        send_desc(1'b1, -1, 1'b0);
        send_desc(1'b0, 0, 1'b0);
        check(wr_index === 2'd0, "R2", "write index wraps", 64'(wr_index), 64'd0);

        // Ring full: new samples drop and raise overflow.
        for (int n = 0; n < 3; n++) begin
            send(16'hDEAD, 16'hBEEF, 1'b1, acc);
            idle(1);
            check(acc == 1'b0, "R5", "model expects drop", 64'(acc), 64'd0);
            check(overflow === 1'b1, "R5", "overflow while dropping", 64'(overflow), 64'd1);
        end

        consume();
        check(rd_index === 2'd1, "R7", "release slot 0", 64'(rd_index), 64'd1);
        consume();
        check(rd_index === 2'd2, "R7", "release slot 1", 64'(rd_index), 64'd2);

        send_desc(1'b1, -1, 1'b1);
        check(overflow === 1'b0, "R5", "overflow clears on accept", 64'(overflow), 64'd0);
        send_desc(1'b0, 27, 1'b0);
        check(wr_index === 2'd2, "R2", "refilled slots wrap", 64'(wr_index), 64'd2);

        for (int n = 0; n < 4; n++) consume();
        check(rd_index === 2'd2, "R7", "read index wraps", 64'(rd_index), 64'd2);
        consume();
        check(rd_index === 2'd2, "R7", "advance ignored when drained", 64'(rd_index), 64'd2);

        send_desc(1'b0, 5, 1'b0);
        idle(10);
        check(q_smp.size() == 0, "R1", "all sample writes seen", 64'(q_smp.size()), 64'd0);
        check(q_hdr.size() == 0, "R6", "all headers seen in sequence", 64'(q_hdr.size()), 64'd0);
        summary();
        $finish;
    end
endmodule